// File: doc/BRIEF.md
# Nibble-Bus Firmware Read Initiator

This block is the host end of a 4-bit firmware memory bus, and it performs single-byte reads. A request names a target device and a 28-bit byte address. The block then runs a fixed framed sequence on the shared nibble bus. It strobes a start code, then sends the device select, the address nibbles, a one-byte size code and a turnaround. At that point it hands the bus to the target. It waits for the target's ready nibble, collects the byte as two nibbles and takes the bus back once the target has finished its own turnaround.

The tri-state bus is split into three signals: a driven value, an enable and a sampled value. Every field value is launched from flops, so it is stable at the rising edge that closes its cycle. The wait for the ready nibble is bounded by a limit input. If the limit runs out, the read is abandoned and a timeout pulse is raised in place of the done pulse.

Top module: `nib_rd_host`

## Requirements
- R1: After reset and whenever idle: busy_o=0, frame_n_o=1, bus_oe_o=1, bus_o=4'b1111, done_o=0, timeout_o=0.
- R2: A request (req_i=1) is taken only while idle. A request raised while busy changes nothing: the frame in progress keeps the device ID and address that were latched at acceptance.
- R3: In the first cycle after acceptance, frame_n_o=0, bus_oe_o=1 and bus_o=4'b1101. In the next cycle frame_n_o returns to 1, and it stays high for the rest of the frame.
- R4: The second frame cycle drives the latched 4-bit device ID.
- R5: Frame cycles 3 to 9 drive the seven address nibbles, most-significant first (cycle 3 carries bits 27:24).
- R6: Frame cycle 10 drives the size code 4'b0000.
- R7: Frame cycle 11 drives 4'b1111 with bus_oe_o=1. From cycle 12 bus_oe_o=0, and it stays 0 until the bus is reclaimed.
- R8: From cycle 13 the block samples bus_i once per cycle. Any value other than 4'b0000 means "not ready yet". The first 4'b0000 is the ready nibble.
- R9: The two nibbles sampled after the ready nibble are the data, low nibble first. data_o = {second nibble, first nibble}.
- R10: bus_oe_o stays 0 for two cycles after the high data nibble. In the cycle after those two, bus_oe_o=1, busy_o=0 and done_o=1 for exactly one cycle, with data_o valid.
- R11: With limit L on wait_lim_i, the ready nibble must come within the first L+1 samples. Otherwise, in the cycle after the last sample, timeout_o=1 for one cycle, busy_o=0, bus_oe_o=1, and done_o stays 0.
- R12: busy_o is 1 from the start cycle until the bus has been reclaimed or the read has timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, taken when idle |
| dev_id_i | input | 4 | Target device select |
| addr_i | input | 28 | Byte address |
| wait_lim_i | input | 8 | Extra samples allowed before the ready nibble |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse: data_o is valid |
| timeout_o | output | 1 | One-cycle pulse: the read was abandoned |
| data_o | output | 8 | Byte that was read |
| frame_n_o | output | 1 | Frame strobe, active low |
| bus_o | output | 4 | Nibble driven onto the bus |
| bus_oe_o | output | 1 | Bus drive enable |
| bus_i | input | 4 | Nibble sampled from the bus |

## Verification
The checker assumes two things about the inputs. First, req_i is a level sampled at the clock. Second, the target only drives bus_i while the block has released the bus, so nothing the target does can make the block drive during the turnaround. The bench plays the target itself. It drives bus_i on falling edges, only in cycles where bus_oe_o is low, and it places the ready nibble at chosen wait counts that lie inside, exactly at, and beyond the limit.

// File: rtl/nib_rd_pkg.sv
package nib_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_IDSEL, ST_ADDR, ST_SIZE, ST_TAR0, ST_TAR1,
    ST_SYNC, ST_DLO, ST_DHI, ST_RTAR0, ST_RTAR1
  } rd_state_e;

  localparam logic [3:0] START_CODE = 4'b1101;
  localparam logic [3:0] SIZE_ONE   = 4'b0000;
  localparam logic [3:0] NIB_IDLE   = 4'b1111;
  localparam logic [3:0] SYNC_READY = 4'b0000;
endpackage

// File: rtl/nib_rd_frame.sv
module nib_rd_frame
  import nib_rd_pkg::*;
#(
  parameter int ADDR_W = 28,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int IDX_W = $clog2(ADDR_NIBS)
) (
  input  rd_state_e         state_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [3:0]        id_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        bus_o,
  output logic              oe_o,
  output logic              frame_n_o
);
  logic [3:0] nibs [ADDR_NIBS];
  logic [3:0] addr_nib;

  // nibs[0] is the most-significant nibble
  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_nib
    assign nibs[g] = addr_i[4*(ADDR_NIBS-1-g) +: 4];
  end

  always_comb begin
    addr_nib = '0;
    for (int k = 0; k < ADDR_NIBS; k++)
      if (idx_i == IDX_W'(k)) addr_nib = nibs[k];
  end

  always_comb begin
    bus_o     = NIB_IDLE;
    oe_o      = 1'b1;
    frame_n_o = 1'b1;
    unique case (state_i)
      ST_START: begin frame_n_o = 1'b0; bus_o = START_CODE; end
      ST_IDSEL: bus_o = id_i;
      ST_ADDR:  bus_o = addr_nib;
      ST_SIZE:  bus_o = SIZE_ONE;
      ST_TAR1, ST_SYNC, ST_DLO, ST_DHI, ST_RTAR0, ST_RTAR1: oe_o = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_rd_timer.sv
module nib_rd_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [WAIT_W-1:0] lim_i,
  output logic              expired_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;

  assign expired_o = (cnt_q == lim_i);
endmodule

// File: rtl/nib_rd_capture.sv
module nib_rd_capture (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_lo_i,
  input  logic       cap_hi_i,
  input  logic [3:0] nib_i,
  output logic [7:0] byte_o
);
  logic [3:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= nib_i;
      if (cap_hi_i) hi_q <= nib_i;
    end

  assign byte_o = {hi_q, lo_q};
endmodule

// File: rtl/nib_rd_host.sv
module nib_rd_host
  import nib_rd_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int WAIT_W = 8,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int IDX_W = $clog2(ADDR_NIBS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        dev_id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WAIT_W-1:0] wait_lim_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [7:0]        data_o,
  output logic              frame_n_o,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  input  logic [3:0]        bus_i
);
  rd_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [3:0]        id_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, to_q, expired;
  logic              in_sync, got_sync;

  assign in_sync  = (state_q == ST_SYNC);
  assign got_sync = in_sync && (bus_i == SYNC_READY);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      id_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          id_q    <= dev_id_i;
          addr_q  <= addr_i;
          state_q <= ST_START;
        end
        ST_START: state_q <= ST_IDSEL;
        ST_IDSEL: begin idx_q <= '0; state_q <= ST_ADDR; end
        ST_ADDR:
          if (idx_q == IDX_W'(ADDR_NIBS-1)) state_q <= ST_SIZE;
          else idx_q <= idx_q + 1'b1;
        ST_SIZE:  state_q <= ST_TAR0;
        ST_TAR0:  state_q <= ST_TAR1;
        ST_TAR1:  state_q <= ST_SYNC;
        ST_SYNC:
          if (got_sync) state_q <= ST_DLO;
          else if (expired) begin
            state_q <= ST_IDLE;
            to_q    <= 1'b1;
          end
        ST_DLO:   state_q <= ST_DHI;
        ST_DHI:   state_q <= ST_RTAR0;
        ST_RTAR0: state_q <= ST_RTAR1;
        ST_RTAR1: begin state_q <= ST_IDLE; done_q <= 1'b1; end
        default:  state_q <= ST_IDLE;
      endcase
    end

  nib_rd_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!in_sync),
    .tick_i   (in_sync && !got_sync),
    .lim_i    (wait_lim_i),
    .expired_o(expired)
  );

  nib_rd_capture i_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_lo_i(state_q == ST_DLO),
    .cap_hi_i(state_q == ST_DHI),
    .nib_i   (bus_i),
    .byte_o  (data_o)
  );

  nib_rd_frame #(.ADDR_W(ADDR_W)) i_frame (
    .state_i  (state_q),
    .idx_i    (idx_q),
    .id_i     (id_q),
    .addr_i   (addr_q),
    .bus_o    (bus_o),
    .oe_o     (bus_oe_o),
    .frame_n_o(frame_n_o)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/nib_rd_host_chk.sv
module nib_rd_host_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input logic       frame_n_o,
  input logic [3:0] bus_o,
  input logic       bus_oe_o
);
  // R1
  idle_drives_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bus_oe_o && frame_n_o));
  // R3
  strobe_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_o |-> (bus_oe_o && bus_o == 4'b1101));
  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_o |=> frame_n_o);
  // R2
  start_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(req_i) && !frame_n_o));
  // R10
  done_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(!bus_oe_o)));
  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  // R11
  timeout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!busy_o && $past(busy_o)));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind nib_rd_host nib_rd_host_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .frame_n_o(frame_n_o),
  .bus_o    (bus_o),
  .bus_oe_o (bus_oe_o)
);

// File: tb/test_nib_rd_host.sv
module test_nib_rd_host;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  dev_id_i = '0;
  logic [27:0] addr_i = '0;
  logic [7:0]  wait_lim_i = '0;
  logic        busy_o, done_o, timeout_o, frame_n_o, bus_oe_o;
  logic [7:0]  data_o;
  logic [3:0]  bus_o;
  logic [3:0]  bus_i = 4'hF;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  nib_rd_host i_nib_rd_host (.*);

  // {id, addr, lim, waits, data, poke}
  localparam int NV = 6;
  localparam logic [56:0] VECS [NV] = '{
    {4'h3, 28'h1234567, 8'd4, 8'd0, 8'hA5, 1'b0},
    {4'hC, 28'hFEDCBA9, 8'd4, 8'd3, 8'h3C, 1'b0},
    {4'h0, 28'h0000001, 8'd2, 8'd2, 8'h81, 1'b0},
    {4'hF, 28'h8000000, 8'd0, 8'd0, 8'hFF, 1'b1},
    {4'h9, 28'h5A5A5A5, 8'd1, 8'd2, 8'h00, 1'b0},
    {4'h6, 28'h0F0F0F0, 8'd0, 8'd1, 8'h00, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(!busy_o && frame_n_o && bus_oe_o && bus_o == 4'hF,
        req, {busy_o, frame_n_o, bus_oe_o, bus_o}, {3'b011, 4'hF});
  endtask

  task automatic run_txn(input logic [3:0] id, input logic [27:0] a,
                         input logic [7:0] lim, input logic [7:0] waits,
                         input logic [7:0] d, input bit poke);
    bit to_exp;
    to_exp = (waits > lim);
    @(negedge clk_i);
    req_i = 1'b1; dev_id_i = id; addr_i = a; wait_lim_i = lim;
    @(negedge clk_i);
    req_i = poke;
    if (poke) begin dev_id_i = ~id; addr_i = ~a; end
    chk(!frame_n_o && bus_oe_o && bus_o == 4'b1101, "R3 start",
        {frame_n_o, bus_oe_o, bus_o}, {2'b01, 4'b1101});
    chk(busy_o, "R12 busy at start", busy_o, 1);
    @(negedge clk_i);
    chk(frame_n_o && bus_o == id, "R4 idsel", {frame_n_o, bus_o}, {1'b1, id});
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      chk(bus_oe_o && frame_n_o && bus_o == a[4*(6-k) +: 4],
          poke ? "R2 addr kept" : "R5 addr", bus_o, a[4*(6-k) +: 4]);
    end
    @(negedge clk_i);
    chk(bus_oe_o && bus_o == 4'b0000, "R6 size", {bus_oe_o, bus_o}, 5'h10);
    @(negedge clk_i);
    chk(bus_oe_o && bus_o == 4'hF, "R7 tar0", {bus_oe_o, bus_o}, 5'h1F);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(!bus_oe_o && busy_o, "R7 tar1 released", {bus_oe_o, busy_o}, 2'b01);
    if (to_exp) begin
      for (int k = 0; k <= int'(lim); k++) begin
        @(negedge clk_i);
        chk(!bus_oe_o && busy_o, "R8 waiting", {bus_oe_o, busy_o}, 2'b01);
        bus_i = 4'h7;
      end
      @(negedge clk_i);
      bus_i = 4'hF;
      chk(timeout_o && !done_o, "R11 timeout pulse", {timeout_o, done_o}, 2'b10);
      chk_idle("R11 idle after timeout");
      @(negedge clk_i);
      chk(!timeout_o, "R11 pulse one cycle", timeout_o, 0);
    end else begin
      for (int k = 0; k < int'(waits) + 5; k++) begin
        @(negedge clk_i);
        chk(!bus_oe_o && busy_o && !done_o, "R10 held off bus",
            {bus_oe_o, busy_o, done_o}, 3'b010);
        if (k < int'(waits))       bus_i = 4'hE;   // not ready
        else if (k == int'(waits)) bus_i = 4'h0;   // ready
        else if (k == int'(waits)+1) bus_i = d[3:0];
        else if (k == int'(waits)+2) bus_i = d[7:4];
        else                       bus_i = 4'hF;
      end
      @(negedge clk_i);
      chk(done_o && !timeout_o, "R10 done pulse", {done_o, timeout_o}, 2'b10);
      chk(data_o == d, "R9 byte order", data_o, d);
      chk_idle("R10 reclaimed");
      @(negedge clk_i);
      chk(!done_o && !busy_o, "R2 no second read", {done_o, busy_o}, 0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk_idle("R1 in reset");
    chk(!done_o && !timeout_o, "R1 pulses low", {done_o, timeout_o}, 0);
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after reset");

    for (int v = 0; v < NV; v++)
      run_txn(VECS[v][56:53], VECS[v][52:25], VECS[v][24:17], VECS[v][16:9],
              VECS[v][8:1], VECS[v][0]);

    // ready nibble on the very last allowed sample (R11 boundary)
    run_txn(4'h1, 28'hABCDEF0, 8'd5, 8'd5, 8'h5A, 1'b0);

    // R12: reset in mid-frame returns to idle
    @(negedge clk_i);
    req_i = 1'b1; addr_i = 28'h1111111; dev_id_i = 4'h2;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(busy_o, "R12 busy mid-frame", busy_o, 1);
    rst_ni = 1'b0;
    #1;
    chk_idle("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 idle after release");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule